// File: doc/BRIEF.md
# Priority-based interrupt presenter

This block keeps the interrupt state of a single processor thread. Routed events arrive on a notify port, each carrying a priority from 0 to 7, and a lower number is more favored. Each event sets one bit of an eight-bit pending bitmap. The most favored pending priority is derived from that bitmap. It is compared against the thread's current priority, which software sets through a write port. When the pending priority is strictly more favored, the block sets an exception flag in its status byte and raises a level interrupt line to the CPU.

Software takes the interrupt through a one-cycle acknowledge request. If the exception flag is set, the acknowledge raises the current priority to the pending one and retires that pending bit. The block returns a 16-bit response: the status byte as it was before the acknowledge, and the current priority after it. A notify in the same cycle as an acknowledge is merged after the acknowledge step, so an event can never be consumed before it has been presented.

Top module: `prio_presenter`

## Requirements
- R1: A notify with priority p in 0..7 sets pending bit (7-p), so priority 0 is the MSB. A notify with priority above 7 sets nothing and cannot raise the line.
- R2: The pending priority is the lowest priority number with its bit set in the pending bitmap. It is 0xFF when the bitmap is empty.
- R3: After reset the line is low, the status and current priority are 0, and the bitmap is empty. Writing 0xFF to the current priority with nothing pending does not raise the line.
- R4: When a notify or a current-priority write leaves the pending priority numerically below the current priority, the exception flag is set and `irq_o` is high from the next clock.
- R5: The comparison is made after every notify and after every current-priority write, so lowering the mask alone can raise the line for an event that is already pending.
- R6: An acknowledge drops `irq_o` on the next clock. If the exception flag was set, the current priority takes the pending priority, that pending bit is cleared and the flag is cleared. Otherwise the state is unchanged.
- R7: `ack_vld_o` pulses high for exactly the clock after each acknowledge. `ack_rsp_o[15:8]` is the status byte before the acknowledge. `ack_rsp_o[7:0]` is the current priority after the acknowledge step, before any write made in the same cycle.
- R8: Same-cycle ordering is acknowledge first, then the current-priority write, then the notify merge, then the comparison on the resulting state.
- R9: A current priority of 0 masks every pending priority. A current priority of 0xFF masks none. A pending priority equal to the current priority does not interrupt.
- R10: The status byte has the exception flag in bit 7, and bits 6..0 always read 0.
- R11: Once raised, the line and the exception flag stay set until an acknowledge, even if the current priority is later changed to mask the pending event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| notify_vld | input | 1 | Routed event present this cycle |
| notify_prio | input | 8 | Priority of the routed event |
| cppr_wr | input | 1 | Write strobe for the current priority |
| cppr_data | input | 8 | New current priority |
| ack_req | input | 1 | One-cycle acknowledge request |
| ack_vld_o | output | 1 | Acknowledge response valid |
| ack_rsp_o | output | 16 | Status byte before the acknowledge, and the current priority after it |
| irq_o | output | 1 | Level interrupt line to the CPU |

## Verification
The bench uses the default parameters: eight priority levels and eight-bit priority fields. With these, every priority from 0 to 7, the out-of-range value 9, and the 0x00 and 0xFF mask extremes can be reached directly. The vector walk covers the equal-priority boundary at 7, two pending events retired one at a time in favor order, and the two same-cycle orderings: acknowledge with notify, and acknowledge with a priority write. A directed reset issued while an interrupt is raised then checks that no phantom interrupt appears on the first write of the current priority.

// File: rtl/prio_presenter.sv
module prio_presenter #(
  parameter int NPRIO = 8,
  parameter int PW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          notify_vld,
  input  logic [PW-1:0] notify_prio,
  input  logic          cppr_wr,
  input  logic [PW-1:0] cppr_data,
  input  logic          ack_req,
  output logic          ack_vld_o,
  output logic [2*PW-1:0] ack_rsp_o,
  output logic          irq_o
);

  localparam int TOP = NPRIO - 1;
  localparam logic [PW-1:0] NONE = '1;

  function automatic logic [NPRIO-1:0] prio_bit(input logic [PW-1:0] p);
    logic [NPRIO-1:0] m;
    m = '0;
    for (int i = 0; i < NPRIO; i++)
      if (p == PW'(i)) m[TOP-i] = 1'b1;
    return m;
  endfunction

  function automatic logic [PW-1:0] first_set(input logic [NPRIO-1:0] b);
    logic [PW-1:0] r;
    r = NONE;
    for (int i = TOP; i >= 0; i--)
      if (b[TOP-i]) r = PW'(i);
    return r;
  endfunction

  logic [NPRIO-1:0] pend_q, pend_a, pend_n, ack_mask;
  logic [PW-1:0]    cppr_q, cppr_a, cppr_n, pipr_q, pipr_n;
  logic             eo_q, eo_a, eo_n, irq_a, irq_n;
  logic [PW-1:0]    nsr;

  assign pipr_q   = first_set(pend_q);
  assign ack_mask = prio_bit(pipr_q);
  assign nsr      = {eo_q, {(PW-1){1'b0}}};

  always_comb begin
    pend_a = pend_q;
    cppr_a = cppr_q;
    eo_a   = eo_q;
    irq_a  = irq_o;
    if (ack_req) begin
      irq_a = 1'b0;
      if (eo_q) begin
        cppr_a = pipr_q;
        pend_a = pend_q & ~ack_mask;
        eo_a   = 1'b0;
      end
    end
    cppr_n = cppr_wr ? cppr_data : cppr_a;
    pend_n = pend_a | (notify_vld ? prio_bit(notify_prio) : '0);
    pipr_n = first_set(pend_n);
    eo_n   = eo_a;
    irq_n  = irq_a;
    if ((notify_vld || cppr_wr) && (pipr_n < cppr_n)) begin
      eo_n  = 1'b1;
      irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      cppr_q    <= '0;
      eo_q      <= 1'b0;
      irq_o     <= 1'b0;
      ack_vld_o <= 1'b0;
      ack_rsp_o <= '0;
    end else begin
      pend_q    <= pend_n;
      cppr_q    <= cppr_n;
      eo_q      <= eo_n;
      irq_o     <= irq_n;
      ack_vld_o <= ack_req;
      if (ack_req) ack_rsp_o <= {nsr, cppr_a};
    end
  end

  AST_LINE_FOLLOWS_EO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == eo_q); // R11

  AST_EO_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    eo_q |-> pend_q != '0); // R4

  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(notify_vld || cppr_wr)); // R5

  AST_ACK_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && !notify_vld && !cppr_wr |=> !irq_o); // R6

  AST_ACK_RETIRES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && eo_q && !notify_vld |=> (pend_q & $past(ack_mask)) == '0); // R6

  AST_ACK_PROMOTES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && eo_q && !cppr_wr |=> cppr_q == $past(pipr_q)); // R6

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_vld_o); // R7

  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_vld_o); // R7

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o |-> ack_rsp_o[2*PW-2:PW] == '0); // R10

endmodule

// File: tb/sim_prio_presenter.sv
`timescale 1ns/1ps
module sim_prio_presenter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic notify_vld = 0, cppr_wr = 0, ack_req = 0;
  logic [7:0] notify_prio = 0, cppr_data = 0;
  logic ack_vld_o, irq_o;
  logic [15:0] ack_rsp_o;
  int runs = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_presenter u0 (.clk(clk), .rst_n(rst_n), .notify_vld(notify_vld),
    .notify_prio(notify_prio), .cppr_wr(cppr_wr), .cppr_data(cppr_data),
    .ack_req(ack_req), .ack_vld_o(ack_vld_o), .ack_rsp_o(ack_rsp_o), .irq_o(irq_o));

  // row: nv, prio, cw, data, ack, exp_irq, exp_rsp (rsp checked when ack)
  localparam int N = 24;
  localparam logic [35:0] TV [N] = '{
    {1'b0,8'h00,1'b0,8'h00,1'b1,1'b0,16'h0000}, // R3 reset state via ack
    {1'b0,8'h00,1'b1,8'hFF,1'b0,1'b0,16'h0000}, // R3 no phantom
    {1'b1,8'h05,1'b0,8'h00,1'b0,1'b1,16'h0000}, // R4 R1
    {1'b1,8'h02,1'b0,8'h00,1'b0,1'b1,16'h0000}, // R1
    {1'b0,8'h00,1'b0,8'h00,1'b1,1'b0,16'h8002}, // R2 R6 R7
    {1'b0,8'h00,1'b0,8'h00,1'b1,1'b0,16'h0002}, // R6 no EO no change
    {1'b0,8'h00,1'b1,8'hFF,1'b0,1'b1,16'h0000}, // R5 R9
    {1'b0,8'h00,1'b0,8'h00,1'b1,1'b0,16'h8005}, // R2
    {1'b0,8'h00,1'b0,8'h00,1'b1,1'b0,16'h0005}, // R10
    {1'b1,8'h09,1'b1,8'hFF,1'b0,1'b0,16'h0000}, // R1 out of range
    {1'b0,8'h00,1'b1,8'h02,1'b0,1'b0,16'h0000}, // R5
    {1'b1,8'h04,1'b0,8'h00,1'b0,1'b0,16'h0000}, // R4 masked
    {1'b0,8'h00,1'b1,8'h05,1'b0,1'b1,16'h0000}, // R5 unmask
    {1'b0,8'h00,1'b1,8'h00,1'b0,1'b1,16'h0000}, // R11 sticky
    {1'b0,8'h00,1'b0,8'h00,1'b1,1'b0,16'h8004}, // R6
    {1'b1,8'h00,1'b1,8'h00,1'b0,1'b0,16'h0000}, // R9 mask all
    {1'b0,8'h00,1'b1,8'hFF,1'b0,1'b1,16'h0000}, // R9
    {1'b1,8'h03,1'b0,8'h00,1'b1,1'b0,16'h8000}, // R8 ack then notify
    {1'b0,8'h00,1'b1,8'h07,1'b0,1'b1,16'h0000}, // R8
    {1'b0,8'h00,1'b0,8'h00,1'b1,1'b0,16'h8003}, // R8
    {1'b1,8'h07,1'b1,8'h07,1'b0,1'b0,16'h0000}, // R9 equal no irq
    {1'b1,8'h06,1'b0,8'h00,1'b0,1'b1,16'h0000}, // R4
    {1'b0,8'h00,1'b1,8'hFF,1'b1,1'b1,16'h8006}, // R8 ack then write
    {1'b0,8'h00,1'b0,8'h00,1'b1,1'b0,16'h8007}  // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic nv, input logic [7:0] p, input logic cw,
                      input logic [7:0] d, input logic ak);
    notify_vld = nv; notify_prio = p; cppr_wr = cw; cppr_data = d; ack_req = ak;
    @(negedge clk);
    notify_vld = 0; cppr_wr = 0; ack_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R3 irq after reset", irq_o, 0);
    chk("R7 no rsp after reset", ack_vld_o, 0);
    for (int i = 0; i < N; i++) begin
      step(TV[i][35], TV[i][34:27], TV[i][26], TV[i][25:18], TV[i][17]);
      chk($sformatf("R4/R6 irq row %0d", i), irq_o, TV[i][16]);
      chk($sformatf("R7 vld row %0d", i), ack_vld_o, TV[i][17]);
      if (TV[i][17]) chk($sformatf("R7 rsp row %0d", i), ack_rsp_o, TV[i][15:0]);
    end
    // directed: reset while raised
    step(1, 8'h00, 1, 8'hFF, 0);
    chk("R4 raise before reset", irq_o, 1);
    rst_n = 0; @(negedge clk); rst_n = 1;
    chk("R3 irq cleared by reset", irq_o, 0);
    step(0, 0, 1, 8'hFF, 0);
    chk("R3 no phantom after reset", irq_o, 0);
    step(0, 0, 0, 0, 1);
    chk("R3 state after reset", ack_rsp_o, 16'h00FF);
    step(0, 0, 0, 0, 0);
    chk("R7 single pulse", ack_vld_o, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule